// File: doc/BRIEF.md
# MMU Fault Syndrome Recorder

This block sits beside an address translation unit and a load/store alignment checker. Each cycle it looks at the outcome of the current memory access. When translation fails or a data access is misaligned, it records a syndrome word and the faulting address. It also raises a one-cycle exception request. The request carries a class, either MMU or hardware, which the vectoring logic uses to pick its handler.

The syndrome word keeps the fault code in its low five bits. Bit 10 marks a store. For misalignment faults, a field supplied by the instruction decoder is placed at a parameterised position. A fault that arrives while an earlier MMU exception is still pending is not recorded. Instead it raises a recursive-fault pulse. A probe-style lookup that misses only reports failure. A software clear returns both registers to zero.

All outputs are registered. They show the effect of the inputs sampled at a rising edge right after that edge.

Top module: `mfsr_recorder`

## Requirements
- R1: A translation result of protection error (`xlat_res_i`=1) on a valid non-probe access loads ESR[4:0] with 17 for an instruction fetch (`acc_kind_i`=0) and 16 for a load (1) or store (2); kind 3 counts as a load.
- R2: A translation result of miss (`xlat_res_i`=2) on a valid non-probe access loads ESR[4:0] with 19 for a fetch and 18 for a data access. Result values 0 and 3 are hits.
- R3: After a translation fault, ESR bit 10 is 1 exactly when the access was a store. All ESR bits other than [4:0] and 10 are 0.
- R4: A recorded translation fault loads EAR with the full address and pulses `exc_req_o` for one cycle with `exc_cls_o`=0 (MMU).
- R5: A fault (translation or alignment) seen while `mmu_pend_i`=1 pulses `recursive_o`, raises no request and leaves ESR and EAR unchanged.
- R6: A misalignment strobe with no translation fault loads ESR[4:0] with 1, loads EAR with the address, and pulses `exc_req_o` with `exc_cls_o`=1 (hardware).
- R7: On a misalignment fault, ESR[ESS_LSB+ESS_W-1:ESS_LSB] (bits 11:5 by default) takes `ess_bits_i` only when `ess_vld_i`=1; otherwise those bits are 0. All other ESR bits are 0.
- R8: A valid probe access (`probe_i`=1) whose translation faults pulses `probe_fail_o` and changes neither ESR nor EAR.
- R9: In a cycle with no recorded fault and no clear, ESR and EAR keep their values.
- R10: Reset sets ESR, EAR and all pulse outputs to zero. `sw_clr_i` zeroes ESR and EAR and suppresses any capture or request in the same cycle.
- R11: If a translation fault and a misalignment strobe arrive in the same cycle, the translation fault is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld_i | input | 1 | A translated access completes this cycle |
| acc_addr_i | input | ADDR_W | Virtual address of the access |
| acc_kind_i | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| xlat_res_i | input | 2 | 0 hit, 1 protection error, 2 miss, 3 hit |
| probe_i | input | 1 | Access is a probe-only lookup |
| unal_stb_i | input | 1 | Misaligned data access detected |
| ess_vld_i | input | 1 | Instruction syndrome field is valid |
| ess_bits_i | input | ESS_W | Instruction-supplied syndrome field |
| mmu_pend_i | input | 1 | An MMU exception is already pending |
| sw_clr_i | input | 1 | Software clear of ESR and EAR |
| esr_o | output | ESR_W | Exception status register |
| ear_o | output | ADDR_W | Exception address register |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_cls_o | output | 1 | Request class: 0 MMU, 1 hardware |
| recursive_o | output | 1 | One-cycle recursive-fault flag |
| probe_fail_o | output | 1 | One-cycle probe failure flag |

## Verification
A wrong syndrome code or a misplaced store or field bit appears on `esr_o` in the first cycle after the faulting access. A stale or spurious capture shows up as an ESR/EAR change in a cycle where the inputs called for none. This is visible one edge after the stimulus. A broken pending or probe path shows up in the same cycle as either a missing pulse or an unwanted overwrite. Comparing every output in every cycle against a reference model therefore catches each of these faults within one cycle.

// File: rtl/mfsr_pkg.sv
package mfsr_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        XL_HIT  = 2'd0,
        XL_PROT = 2'd1,
        XL_MISS = 2'd2,
        XL_NONE = 2'd3
    } xlat_res_e;

    typedef enum logic {
        CLS_MMU = 1'b0,
        CLS_HW  = 1'b1
    } exc_cls_e;

    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_XLAT = 2'd1,
        EV_UNAL = 2'd2
    } fault_ev_e;

    localparam int unsigned CODE_W      = 5;
    localparam int unsigned STORE_BIT   = 10;
    localparam logic [CODE_W-1:0] CODE_XLAT_BASE = 5'd16;
    localparam logic [CODE_W-1:0] CODE_UNALIGN   = 5'd1;

endpackage

// File: rtl/mfsr_classify.sv
module mfsr_classify
    import mfsr_pkg::*;
(
    input  logic      acc_vld_i,
    input  logic      probe_i,
    input  xlat_res_e xlat_res_i,
    input  logic      unal_stb_i,
    input  logic      mmu_pend_i,
    output fault_ev_e event_o,
    output logic      probe_miss_o,
    output logic      recursive_o
);

    logic xlat_fault;
    logic real_xlat;
    logic any_fault;

    always_comb begin
        xlat_fault   = acc_vld_i && ((xlat_res_i == XL_PROT) || (xlat_res_i == XL_MISS));
        real_xlat    = xlat_fault && !probe_i;
        probe_miss_o = xlat_fault && probe_i;
        any_fault    = real_xlat || unal_stb_i;
        recursive_o  = any_fault && mmu_pend_i;
        if (!any_fault || mmu_pend_i) begin
            event_o = EV_IDLE;
        end else if (real_xlat) begin
            event_o = EV_XLAT;
        end else begin
            event_o = EV_UNAL;
        end
    end

endmodule

// File: rtl/mfsr_syndrome.sv
module mfsr_syndrome
    import mfsr_pkg::*;
#(
    parameter int unsigned ESR_W   = 32,
    parameter int unsigned ESS_W   = 7,
    parameter int unsigned ESS_LSB = 5
) (
    input  fault_ev_e          event_i,
    input  acc_kind_e          acc_kind_i,
    input  xlat_res_e          xlat_res_i,
    input  logic               ess_vld_i,
    input  logic [ESS_W-1:0]   ess_bits_i,
    output logic [ESR_W-1:0]   esr_o
);

    logic [CODE_W-1:0] xlat_code;

    always_comb begin
        xlat_code = CODE_XLAT_BASE;
        if (xlat_res_i == XL_MISS) begin
            xlat_code = xlat_code + 5'd2;
        end
        if (acc_kind_i == ACC_FETCH) begin
            xlat_code = xlat_code + 5'd1;
        end

        esr_o = '0;
        case (event_i)
            EV_XLAT: begin
                esr_o[CODE_W-1:0] = xlat_code;
                esr_o[STORE_BIT]  = (acc_kind_i == ACC_STORE);
            end
            EV_UNAL: begin
                esr_o[CODE_W-1:0] = CODE_UNALIGN;
                if (ess_vld_i) begin
                    esr_o[ESS_LSB +: ESS_W] = ess_bits_i;
                end
            end
            default: esr_o = '0;
        endcase
    end

endmodule

// File: rtl/mfsr_recorder.sv
module mfsr_recorder
    import mfsr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ESR_W   = 32,
    parameter int unsigned ESS_W   = 7,
    parameter int unsigned ESS_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [1:0]        acc_kind_i,
    input  logic [1:0]        xlat_res_i,
    input  logic              probe_i,
    input  logic              unal_stb_i,
    input  logic              ess_vld_i,
    input  logic [ESS_W-1:0]  ess_bits_i,
    input  logic              mmu_pend_i,
    input  logic              sw_clr_i,
    output logic [ESR_W-1:0]  esr_o,
    output logic [ADDR_W-1:0] ear_o,
    output logic              exc_req_o,
    output logic              exc_cls_o,
    output logic              recursive_o,
    output logic              probe_fail_o
);

    typedef struct packed {
        logic [ESR_W-1:0]  esr;
        logic [ADDR_W-1:0] ear;
        logic              req;
        exc_cls_e          cls;
        logic              rec;
        logic              pfail;
    } rec_state_t;

    rec_state_t state_d, state_q;

    fault_ev_e        ev;
    logic             probe_miss;
    logic             rec_hit;
    logic [ESR_W-1:0] syn;

    mfsr_classify u_classify (
        .acc_vld_i    (acc_vld_i),
        .probe_i      (probe_i),
        .xlat_res_i   (xlat_res_e'(xlat_res_i)),
        .unal_stb_i   (unal_stb_i),
        .mmu_pend_i   (mmu_pend_i),
        .event_o      (ev),
        .probe_miss_o (probe_miss),
        .recursive_o  (rec_hit)
    );

    mfsr_syndrome #(
        .ESR_W   (ESR_W),
        .ESS_W   (ESS_W),
        .ESS_LSB (ESS_LSB)
    ) u_syndrome (
        .event_i    (ev),
        .acc_kind_i (acc_kind_e'(acc_kind_i)),
        .xlat_res_i (xlat_res_e'(xlat_res_i)),
        .ess_vld_i  (ess_vld_i),
        .ess_bits_i (ess_bits_i),
        .esr_o      (syn)
    );

    always_comb begin
        state_d       = state_q;
        state_d.req   = 1'b0;
        state_d.rec   = rec_hit;
        state_d.pfail = probe_miss;
        if (ev != EV_IDLE) begin
            state_d.esr = syn;
            state_d.ear = acc_addr_i;
            state_d.req = 1'b1;
            state_d.cls = (ev == EV_XLAT) ? CLS_MMU : CLS_HW;
        end
        if (sw_clr_i) begin
            state_d.esr = '0;
            state_d.ear = '0;
            state_d.req = 1'b0;
            state_d.cls = state_q.cls;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign esr_o        = state_q.esr;
    assign ear_o        = state_q.ear;
    assign exc_req_o    = state_q.req;
    assign exc_cls_o    = state_q.cls;
    assign recursive_o  = state_q.rec;
    assign probe_fail_o = state_q.pfail;

endmodule

// File: rtl/mfsr_recorder_chk.sv
module mfsr_recorder_chk #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ESR_W   = 32,
    parameter int unsigned ESS_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_vld_i,
    input logic [1:0]        acc_kind_i,
    input logic [1:0]        xlat_res_i,
    input logic              probe_i,
    input logic              unal_stb_i,
    input logic              sw_clr_i,
    input logic [ESR_W-1:0]  esr_o,
    input logic [ADDR_W-1:0] ear_o,
    input logic              exc_req_o,
    input logic              exc_cls_o,
    input logic              recursive_o,
    input logic              probe_fail_o
);

    logic capture_in;
    assign capture_in = (acc_vld_i && !probe_i && (xlat_res_i == 2'd1 || xlat_res_i == 2'd2))
                        || unal_stb_i || sw_clr_i;

    // R3: store flag follows the access kind of an MMU-class capture
    p_store_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_o && !exc_cls_o) |-> (esr_o[10] == $past(acc_kind_i == 2'd2)));

    // R6: hardware-class requests carry the misalignment code
    p_unal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_o && exc_cls_o) |-> (esr_o[4:0] == 5'd1));

    // R5: a recursive fault raises no request and leaves the registers alone
    p_recursive_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (recursive_o && !$past(sw_clr_i)) |-> (!exc_req_o && $stable(esr_o) && $stable(ear_o)));

    // R8: a failed probe never raises a request on its own
    p_probe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_fail_o && !$past(unal_stb_i) && !$past(sw_clr_i)) |-> (!exc_req_o && $stable(esr_o)));

    // R9: no fault and no clear means the registers hold
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture_in) |-> ($stable(esr_o) && $stable(ear_o)));

    // R10: a clear leaves zeroed registers and no request
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_clr_i) |-> (esr_o == '0 && ear_o == '0 && !exc_req_o));

endmodule

bind mfsr_recorder mfsr_recorder_chk #(
    .ADDR_W (ADDR_W),
    .ESR_W  (ESR_W),
    .ESS_W  (ESS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_vld_i    (acc_vld_i),
    .acc_kind_i   (acc_kind_i),
    .xlat_res_i   (xlat_res_i),
    .probe_i      (probe_i),
    .unal_stb_i   (unal_stb_i),
    .sw_clr_i     (sw_clr_i),
    .esr_o        (esr_o),
    .ear_o        (ear_o),
    .exc_req_o    (exc_req_o),
    .exc_cls_o    (exc_cls_o),
    .recursive_o  (recursive_o),
    .probe_fail_o (probe_fail_o)
);

// File: tb/mfsr_recorder_tb.sv
module mfsr_recorder_tb;

    localparam int unsigned AW  = 32;
    localparam int unsigned EW  = 32;
    localparam int unsigned SW  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_vld = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_kind = '0;
    logic [1:0]    xlat_res = '0;
    logic          probe = 1'b0;
    logic          unal = 1'b0;
    logic          ess_vld = 1'b0;
    logic [SW-1:0] ess = '0;
    logic          pend = 1'b0;
    logic          clr = 1'b0;
    logic [EW-1:0] esr;
    logic [AW-1:0] ear;
    logic          req, cls, rec, pfail;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [EW-1:0] m_esr = '0;
    logic [AW-1:0] m_ear = '0;
    logic          m_req = 1'b0, m_cls = 1'b0, m_rec = 1'b0, m_pf = 1'b0;
    string         m_tag = "R10";

    always #2.5 clk = ~clk;

    mfsr_recorder #(.ADDR_W(AW), .ESR_W(EW), .ESS_W(SW), .ESS_LSB(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_vld_i(acc_vld), .acc_addr_i(acc_addr),
        .acc_kind_i(acc_kind), .xlat_res_i(xlat_res), .probe_i(probe),
        .unal_stb_i(unal), .ess_vld_i(ess_vld), .ess_bits_i(ess),
        .mmu_pend_i(pend), .sw_clr_i(clr), .esr_o(esr), .ear_o(ear),
        .exc_req_o(req), .exc_cls_o(cls), .recursive_o(rec), .probe_fail_o(pfail)
    );

    function automatic logic [EW-1:0] xlat_esr(logic [1:0] k, logic [1:0] r);
        logic [EW-1:0] v;
        v = (r == 2'd1) ? ((k == 2'd0) ? 32'd17 : 32'd16)
                        : ((k == 2'd0) ? 32'd19 : 32'd18);
        if (k == 2'd2) v = v | 32'h400;
        return v;
    endfunction

    function automatic logic [EW-1:0] unal_esr(logic v, logic [SW-1:0] b);
        return v ? (32'd1 | (32'(b) << 5)) : 32'd1;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", m_tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk(64'(esr), 64'(m_esr), "esr");
        chk(64'(ear), 64'(m_ear), "ear");
        chk(64'(req), 64'(m_req), "req");
        if (m_req) chk(64'(cls), 64'(m_cls), "class");
        chk(64'(rec), 64'(m_rec), "recursive");
        chk(64'(pfail), 64'(m_pf), "probe_fail");
    endtask

    // Drive one cycle of stimulus at the falling edge, update the model, check after the next edge.
    task automatic step(input logic v, input logic [AW-1:0] a, input logic [1:0] k,
                        input logic [1:0] r, input logic p, input logic u,
                        input logic ev, input logic [SW-1:0] eb,
                        input logic pd, input logic c);
        logic tf, tfx, pm, anyf;
        acc_vld = v; acc_addr = a; acc_kind = k; xlat_res = r; probe = p;
        unal = u; ess_vld = ev; ess = eb; pend = pd; clr = c;
        tf   = v && (r == 2'd1 || r == 2'd2);
        tfx  = tf && !p;
        pm   = tf && p;
        anyf = tfx || u;
        m_req = 1'b0;
        m_rec = anyf && pd;
        m_pf  = pm;
        if (c)                 m_tag = "R10";
        else if (anyf && pd)   m_tag = "R5";
        else if (pm && !u)     m_tag = "R8";
        else if (tfx && u)     m_tag = "R11";
        else if (tfx)          m_tag = (k == 2'd2) ? "R3" : ((r == 2'd1) ? "R1" : "R2");
        else if (u)            m_tag = ev ? "R7" : "R6";
        else                   m_tag = "R9";
        if (anyf && !pd) begin
            m_esr = tfx ? xlat_esr(k, r) : unal_esr(ev, eb);
            m_ear = a;
            m_req = 1'b1;
            m_cls = tfx ? 1'b0 : 1'b1;
            if (tfx && m_tag == "R9") m_tag = "R4";
        end
        if (c) begin
            m_esr = '0; m_ear = '0; m_req = 1'b0;
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        m_tag = "R10";
        check_all();
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // Directed corners
        step(1, 32'hDEAD_BEE0, 2'd0, 2'd1, 0, 0, 0, '0, 0, 0);           // R1 fetch prot -> 17
        step(1, 32'h1000_0004, 2'd1, 2'd1, 0, 0, 0, '0, 0, 0);           // R1 load prot -> 16
        step(1, 32'h2000_0008, 2'd0, 2'd2, 0, 0, 0, '0, 0, 0);           // R2 fetch miss -> 19
        step(1, 32'hFFFF_FFFC, 2'd2, 2'd2, 0, 0, 0, '0, 0, 0);           // R3 store miss -> 0x412, R4 full addr
        step(0, 32'h0, 2'd0, 2'd0, 0, 0, 0, '0, 0, 0);                   // R9 hold
        step(1, 32'h3000_0000, 2'd1, 2'd0, 0, 0, 0, '0, 0, 0);           // R9 hit holds
        step(1, 32'h4000_0001, 2'd1, 2'd0, 0, 1, 1, 7'h5A, 0, 0);        // R7 field merged -> 0xB41
        step(1, 32'h4000_0003, 2'd2, 2'd0, 0, 1, 0, 7'h7F, 0, 0);        // R6 field dropped -> 1
        step(1, 32'h5000_0000, 2'd2, 2'd1, 0, 0, 0, '0, 1, 0);           // R5 recursive
        step(1, 32'h6000_0000, 2'd0, 2'd2, 1, 0, 0, '0, 0, 0);           // R8 probe miss
        step(1, 32'h7000_0000, 2'd2, 2'd1, 0, 1, 1, 7'h11, 0, 0);        // R11 translation wins
        step(1, 32'h8000_0000, 2'd0, 2'd2, 0, 0, 0, '0, 0, 1);           // R10 clear wins
        step(1, 32'h9000_0000, 2'd3, 2'd1, 0, 0, 0, '0, 0, 0);           // R1 kind 3 as load

        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, $urandom, 2'($urandom), 2'($urandom),
                 ($urandom % 5) == 0, ($urandom % 6) == 0, $urandom % 2, 7'($urandom),
                 ($urandom % 5) == 0, ($urandom % 20) == 0);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule